// File: doc/BRIEF.md
# Three-Channel Interval Timer with Byte-Wide Register Access

This block holds three independent 16-bit down-counters behind an 8-bit register interface. Addresses 0 to 2 are the per-channel data ports and address 3 is the control port. Software writes a control word to choose a channel's access order, output mode and number base. It then loads a reload value one or two bytes at a time. It can freeze a count or a status snapshot for later readback, either one channel at a time or several at once. All channels count on a shared clock-enable input, `tick`, which stands in for the nominal 1.19318 MHz timer clock. Each channel drives an output level. The last channel can also drive a speaker line through a separate two-bit enable.

Reads are combinational: `rd_data` shows the selected byte in the same cycle that `rd_en` is high. The side effects of the read take place at the following clock edge. These are toggle advance, latch release and status release. All bus operations and counting operations that fall in one cycle act on the state as it was before that edge.

Top module: `pit_timer3`

## Requirements
- R1: A write to address 3 is a control word. Bits 7:6 are the channel, and the value 3 marks a read-back command. Bits 5:4 are the access field: 0 latch, 1 low byte only, 2 high byte only, 3 low byte then high byte. Bits 3:1 are the mode and bit 0 selects BCD. Addresses 0 to 2 are the data ports of channels 0 to 2.
- R2: A control word with a nonzero access field stores bits 5:0 for its channel. It clears the reload value to zero, sets the null-count flag and sets the output high. It also drops any unread latch, any pending status and both byte toggles. The count holds its value.
- R3: With access 3, a write toggle and a separate read toggle each pick the low byte first and the high byte second. With access 1 or 2, only that byte is written or read.
- R4: Programming is complete after the single byte in access 1 or 2, or after the high byte in access 3. The first tick after that loads the count from the reload value and clears null count. While null count is set and programming is incomplete, the count holds.
- R5: A latch command captures the current count only when the channel holds no unread latched count. The latch is released once its last byte has been read.
- R6: In a read-back command, bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 clear latches their counts. Bit 4 clear captures their status, but only on channels with no status already pending.
- R7: A pending status byte is returned before any count data and is released by that read. Its bits 5:0 are the stored control bits, bit 6 is null count and bit 7 is the output level.
- R8: In binary mode a running count steps down by one modulo 65536 on each tick. A count of 1 reloads, so a reload of 0 gives a period of 65536 ticks.
- R9: In BCD mode the count steps down in decimal modulo 10000. A count of 0 steps to 9999.
- R10: When mode bits 2:1 are both set, the output toggles at each reload. In all other modes the output goes low for the one tick period that follows a reload and is high otherwise.
- R11: With access 0, a data-port read returns 0 and changes nothing. A read of address 3 returns 0, and `rd_data` is 0 whenever `rd_en` is low.
- R12: `spk_out` follows the channel 2 output only while both bits of `spk_ctl` are set, and is 0 otherwise.
- R13: If a tick and a latch command fall in the same cycle, the latch captures the count from before the tick. If a control word and a tick reach the same channel together, the control word wins and the count does not step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Shared count enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 to 2 data ports, 3 control |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid while rd_en is high |
| ch_out | output | 3 | Output level of each channel |
| spk_ctl | input | 2 | Speaker gate; both bits set enables it |
| spk_out | output | 1 | Gated channel 2 output |

## Verification
A bus operation and a counting tick can reach the same channel in one clock. The block must then give the operation a pre-edge view of the counter. The bench provokes this by issuing a latch command with `tick` high in the same cycle, and by writing a control word while the channel sits at its reload point with `tick` high. Its behavioural model applies the tick first and the bus operation on top, and then compares every output each cycle. Directed reads confirm that the captured value is the pre-tick count and that the counter did not step past the control word.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;

   localparam int PIT_BCD_DIGITS = 4;

   typedef enum logic [1:0] {
      ACC_LATCH = 2'd0,
      ACC_LOW   = 2'd1,
      ACC_HIGH  = 2'd2,
      ACC_PAIR  = 2'd3
   } pit_access_e;

   typedef struct packed {
      logic       level;
      logic       null_cnt;
      logic [5:0] cw;
   } pit_status_t;

   // Decimal decrement with borrow across nibbles; 0000 wraps to 9999.
   function automatic logic [4*PIT_BCD_DIGITS-1:0] bcd_minus_one(
      input logic [4*PIT_BCD_DIGITS-1:0] v);
      logic [4*PIT_BCD_DIGITS-1:0] r;
      logic borrow;
      r = v;
      borrow = 1'b1;
      for (int d = 0; d < PIT_BCD_DIGITS; d++) begin
         if (borrow) begin
            if (v[4*d +: 4] == 4'd0) begin
               r[4*d +: 4] = 4'd9;
            end else begin
               r[4*d +: 4] = v[4*d +: 4] - 4'd1;
               borrow = 1'b0;
            end
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/pit_bus_decode.sv
`timescale 1ns/1ps
module pit_bus_decode #(
   parameter int NUM_CH    = 3,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 2,
   parameter int CTRL_ADDR = 3
) (
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [NUM_CH-1:0] cw_load,
   output logic [5:0]        cw_word,
   output logic [NUM_CH-1:0] cnt_latch,
   output logic [NUM_CH-1:0] st_latch,
   output logic [NUM_CH-1:0] data_wr,
   output logic [NUM_CH-1:0] data_rd
);
   logic       ctl_wr;
   logic [1:0] sel;
   logic [1:0] acc;
   logic       is_rb;

   assign ctl_wr  = wr_en && (addr == ADDR_W'(CTRL_ADDR));
   assign sel     = wdata[7:6];
   assign acc     = wdata[5:4];
   assign is_rb   = (sel == 2'b11);
   assign cw_word = wdata[5:0];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit;
      assign hit          = !is_rb && (sel == 2'(i));
      assign cw_load[i]   = ctl_wr && hit && (acc != 2'b00);
      assign cnt_latch[i] = ctl_wr && ((hit && (acc == 2'b00)) ||
                                       (is_rb && !wdata[5] && wdata[i+1]));
      assign st_latch[i]  = ctl_wr && is_rb && !wdata[4] && wdata[i+1];
      assign data_wr[i]   = wr_en && (addr == ADDR_W'(i));
      assign data_rd[i]   = rd_en && (addr == ADDR_W'(i));
   end

endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel import pit_pkg::*; #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16,
   parameter bit BCD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              cw_load,
   input  logic [5:0]        cw_word,
   input  logic              cnt_latch,
   input  logic              st_latch,
   input  logic              data_wr,
   input  logic              data_rd,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_byte,
   output logic              out_o
);
   logic [5:0]       ctrl_q;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] lval_q;
   logic             pend_q;
   logic             ready_q;
   logic             out_q;
   logic             rtog_q;
   logic             wtog_q;
   logic             lat_q;
   logic             spend_q;
   pit_status_t      sval_q;

   pit_access_e      acc;
   logic             square;
   logic             terminal;
   logic [CNT_W-1:0] dec_val;
   logic [CNT_W-1:0] view;

   assign acc      = pit_access_e'(ctrl_q[5:4]);
   assign square   = (ctrl_q[2:1] == 2'b11);
   assign terminal = (count_q == CNT_W'(1));
   assign view     = lat_q ? lval_q : count_q;
   assign out_o    = out_q;

   if (BCD_EN) begin : g_bcd
      assign dec_val = ctrl_q[0] ? bcd_minus_one(count_q) : count_q - CNT_W'(1);
   end else begin : g_bin
      assign dec_val = count_q - CNT_W'(1);
   end

   always_comb begin
      rd_byte = '0;
      if (spend_q) begin
         rd_byte = sval_q;
      end else begin
         case (acc)
            ACC_LOW:  rd_byte = view[DATA_W-1:0];
            ACC_HIGH: rd_byte = view[CNT_W-1 -: DATA_W];
            ACC_PAIR: rd_byte = rtog_q ? view[CNT_W-1 -: DATA_W] : view[DATA_W-1:0];
            default:  rd_byte = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         reload_q <= '0;
         count_q  <= '0;
         lval_q   <= '0;
         pend_q   <= 1'b1;
         ready_q  <= 1'b0;
         out_q    <= 1'b1;
         rtog_q   <= 1'b0;
         wtog_q   <= 1'b0;
         lat_q    <= 1'b0;
         spend_q  <= 1'b0;
         sval_q   <= '0;
      end else begin
         // counting, suppressed by a control word to this channel
         if (tick && !cw_load) begin
            if (pend_q && ready_q) begin
               count_q <= reload_q;
               pend_q  <= 1'b0;
            end else if (!pend_q) begin
               if (terminal) begin
                  count_q <= reload_q;
                  out_q   <= square ? ~out_q : 1'b0;
               end else begin
                  count_q <= dec_val;
                  if (!square) out_q <= 1'b1;
               end
            end
         end

         if (cw_load) begin
            ctrl_q   <= cw_word;
            reload_q <= '0;
            pend_q   <= 1'b1;
            ready_q  <= 1'b0;
            out_q    <= 1'b1;
            rtog_q   <= 1'b0;
            wtog_q   <= 1'b0;
            lat_q    <= 1'b0;
            spend_q  <= 1'b0;
         end else begin
            if (cnt_latch && !lat_q) begin
               lat_q  <= 1'b1;
               lval_q <= count_q;
            end
            if (st_latch && !spend_q) begin
               spend_q <= 1'b1;
               sval_q  <= '{level: out_q, null_cnt: pend_q, cw: ctrl_q};
            end
            if (data_wr) begin
               case (acc)
                  ACC_LOW: begin
                     reload_q[DATA_W-1:0] <= wdata;
                     pend_q  <= 1'b1;
                     ready_q <= 1'b1;
                  end
                  ACC_HIGH: begin
                     reload_q[CNT_W-1 -: DATA_W] <= wdata;
                     pend_q  <= 1'b1;
                     ready_q <= 1'b1;
                  end
                  ACC_PAIR: begin
                     wtog_q <= ~wtog_q;
                     pend_q <= 1'b1;
                     if (!wtog_q) begin
                        reload_q[DATA_W-1:0] <= wdata;
                        ready_q <= 1'b0;
                     end else begin
                        reload_q[CNT_W-1 -: DATA_W] <= wdata;
                        ready_q <= 1'b1;
                     end
                  end
                  default: ;
               endcase
            end
            if (data_rd) begin
               if (spend_q) begin
                  spend_q <= 1'b0;
               end else begin
                  case (acc)
                     ACC_LOW, ACC_HIGH: lat_q <= 1'b0;
                     ACC_PAIR: begin
                        rtog_q <= ~rtog_q;
                        if (rtog_q) lat_q <= 1'b0;
                     end
                     default: ;
                  endcase
               end
            end
         end
      end
   end

   AST_CW_CLEARS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cw_load |=> (reload_q == '0 && pend_q && !ready_q && out_q)); // R2
   AST_UNREADY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !ready_q) |=> $stable(count_q)); // R4
   AST_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && pend_q && ready_q && !cw_load && !data_wr)
         |=> (!pend_q && count_q == $past(reload_q))); // R4
   AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_q && !data_rd && !cw_load) |=> (lat_q && $stable(lval_q))); // R5
   AST_STATUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (spend_q && data_rd && !cw_load) |=> !spend_q); // R7

endmodule

// File: rtl/pit_read_mux.sv
`timescale 1ns/1ps
module pit_read_mux #(
   parameter int NUM_CH = 3,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic                           rd_en,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [NUM_CH-1:0][DATA_W-1:0]  ch_bytes,
   output logic [DATA_W-1:0]              rd_data
);
   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (rd_en && (addr == ADDR_W'(i))) rd_data = ch_bytes[i];
      end
   end
endmodule

// File: rtl/pit_timer3.sv
`timescale 1ns/1ps
module pit_timer3 #(
   parameter int NUM_CH = 3,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 2,
   parameter bit BCD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic [NUM_CH-1:0] ch_out,
   input  logic [1:0]        spk_ctl,
   output logic              spk_out
);
   localparam int CTRL_ADDR = (1 << ADDR_W) - 1;
   localparam int SPK_CH    = NUM_CH - 1;

   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_ch
      $error("NUM_CH must lie between 1 and 3");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("DATA_W must be 8 for the control word layout");
   end
   if (CNT_W != 2 * DATA_W) begin : g_bad_cnt
      $error("CNT_W must be twice DATA_W");
   end
   if (ADDR_W != 2) begin : g_bad_addr
      $error("ADDR_W must be 2");
   end

   logic [NUM_CH-1:0]             cw_load;
   logic [5:0]                    cw_word;
   logic [NUM_CH-1:0]             cnt_latch;
   logic [NUM_CH-1:0]             st_latch;
   logic [NUM_CH-1:0]             data_wr;
   logic [NUM_CH-1:0]             data_rd;
   logic [NUM_CH-1:0][DATA_W-1:0] ch_bytes;

   pit_bus_decode #(
      .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
   ) u_dec (
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
      .cw_load(cw_load), .cw_word(cw_word), .cnt_latch(cnt_latch),
      .st_latch(st_latch), .data_wr(data_wr), .data_rd(data_rd)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      pit_channel #(.DATA_W(DATA_W), .CNT_W(CNT_W), .BCD_EN(BCD_EN)) u_ch (
         .clk(clk), .rst_n(rst_n), .tick(tick),
         .cw_load(cw_load[i]), .cw_word(cw_word),
         .cnt_latch(cnt_latch[i]), .st_latch(st_latch[i]),
         .data_wr(data_wr[i]), .data_rd(data_rd[i]), .wdata(wdata),
         .rd_byte(ch_bytes[i]), .out_o(ch_out[i])
      );
   end

   pit_read_mux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rmux (
      .rd_en(rd_en), .addr(addr), .ch_bytes(ch_bytes), .rd_data(rd_data)
   );

   assign spk_out = ch_out[SPK_CH] & spk_ctl[0] & spk_ctl[1];

   AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(CTRL_ADDR)) |-> (rd_data == '0)); // R11
   AST_SPK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (spk_ctl != 2'b11) |-> !spk_out); // R12
   AST_ONE_CW: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cw_load)); // R1

endmodule

// File: tb/pit_timer3_test.sv
`timescale 1ns/1ps
module pit_timer3_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [1:0] spk_ctl = 2'd0;
   logic [7:0] rd_data;
   logic [2:0] ch_out;
   logic       spk_out;

   always #4 clk = ~clk;

   pit_timer3 uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rd_data(rd_data), .ch_out(ch_out),
      .spk_ctl(spk_ctl), .spk_out(spk_out)
   );

   int n_chk = 0, n_fail = 0;
   int m_ctrl[3], m_reload[3], m_count[3], m_pend[3], m_ready[3], m_out[3];
   int m_rt[3], m_wt[3], m_lat[3], m_lv[3], m_sp[3], m_sv[3];

   function automatic int bcd2int(int v);
      return (v & 15) + ((v >> 4) & 15) * 10 + ((v >> 8) & 15) * 100 + ((v >> 12) & 15) * 1000;
   endfunction
   function automatic int int2bcd(int v);
      return (v % 10) | ((v / 10 % 10) << 4) | ((v / 100 % 10) << 8) | ((v / 1000 % 10) << 12);
   endfunction
   function automatic int step_down(int v, int bcd);
      if (bcd != 0) return int2bcd((bcd2int(v) + 9999) % 10000);
      return (v + 65535) % 65536;
   endfunction

   function automatic int model_rd();
      int a, v;
      if (!rd_en || addr == 2'd3) return 0;
      a = int'(addr);
      if (m_sp[a] != 0) return m_sv[a];
      v = (m_lat[a] != 0) ? m_lv[a] : m_count[a];
      case ((m_ctrl[a] >> 4) & 3)
         1: return v & 255;
         2: return (v >> 8) & 255;
         3: return (m_rt[a] != 0) ? ((v >> 8) & 255) : (v & 255);
         default: return 0;
      endcase
   endfunction

   // behavioural reference: tick first, bus operation on top, both from pre-edge state
   always @(posedge clk) begin
      for (int i = 0; i < 3; i++) begin
         int c, rl, pd, rdy, o, rt, wt, lt, lv, sp, sv, ct, acc;
         bit sq, cw, lc, sc, dw, dr;
         if (!rst_n) begin
            m_ctrl[i] = 0; m_reload[i] = 0; m_count[i] = 0; m_pend[i] = 1;
            m_ready[i] = 0; m_out[i] = 1; m_rt[i] = 0; m_wt[i] = 0;
            m_lat[i] = 0; m_lv[i] = 0; m_sp[i] = 0; m_sv[i] = 0;
         end else begin
            c = m_count[i]; rl = m_reload[i]; pd = m_pend[i]; rdy = m_ready[i];
            o = m_out[i]; rt = m_rt[i]; wt = m_wt[i]; lt = m_lat[i];
            lv = m_lv[i]; sp = m_sp[i]; sv = m_sv[i]; ct = m_ctrl[i];
            acc = (m_ctrl[i] >> 4) & 3;
            sq = (((m_ctrl[i] >> 1) & 3) == 3);
            cw = wr_en && addr == 2'd3 && int'(wdata[7:6]) == i && wdata[5:4] != 2'd0;
            lc = wr_en && addr == 2'd3 && ((int'(wdata[7:6]) == i && wdata[5:4] == 2'd0) ||
                 (wdata[7:6] == 2'd3 && !wdata[5] && wdata[i+1]));
            sc = wr_en && addr == 2'd3 && wdata[7:6] == 2'd3 && !wdata[4] && wdata[i+1];
            dw = wr_en && int'(addr) == i;
            dr = rd_en && int'(addr) == i;
            if (tick && !cw) begin
               if (m_pend[i] != 0 && m_ready[i] != 0) begin
                  c = m_reload[i]; pd = 0;
               end else if (m_pend[i] == 0) begin
                  if (m_count[i] == 1) begin
                     c = m_reload[i];
                     o = sq ? 1 - m_out[i] : 0;
                  end else begin
                     c = step_down(m_count[i], m_ctrl[i] & 1);
                     if (!sq) o = 1;
                  end
               end
            end
            if (cw) begin
               ct = int'(wdata[5:0]); rl = 0; pd = 1; rdy = 0; o = 1;
               rt = 0; wt = 0; lt = 0; sp = 0;
            end else begin
               if (lc && m_lat[i] == 0) begin lt = 1; lv = m_count[i]; end
               if (sc && m_sp[i] == 0) begin
                  sp = 1; sv = m_out[i] * 128 + m_pend[i] * 64 + m_ctrl[i];
               end
               if (dw) begin
                  case (acc)
                     1: begin rl = (rl & 'hff00) | int'(wdata); pd = 1; rdy = 1; end
                     2: begin rl = (rl & 'h00ff) | (int'(wdata) << 8); pd = 1; rdy = 1; end
                     3: begin
                        pd = 1; wt = 1 - m_wt[i];
                        if (m_wt[i] == 0) begin rl = (rl & 'hff00) | int'(wdata); rdy = 0; end
                        else begin rl = (rl & 'h00ff) | (int'(wdata) << 8); rdy = 1; end
                     end
                     default: ;
                  endcase
               end
               if (dr) begin
                  if (m_sp[i] != 0) sp = 0;
                  else if (acc == 1 || acc == 2) lt = 0;
                  else if (acc == 3) begin
                     rt = 1 - m_rt[i];
                     if (m_rt[i] != 0) lt = 0;
                  end
               end
            end
            m_count[i] = c; m_reload[i] = rl; m_pend[i] = pd; m_ready[i] = rdy;
            m_out[i] = o; m_rt[i] = rt; m_wt[i] = wt; m_lat[i] = lt;
            m_lv[i] = lv; m_sp[i] = sp; m_sv[i] = sv; m_ctrl[i] = ct;
         end
      end
   end

   task automatic chk(input int act, input int exp, input string tag);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input bit w, input bit r, input logic [1:0] a, input logic [7:0] d,
                      input bit tk, input string tag, input int exp = -1);
      @(negedge clk);
      wr_en = w; rd_en = r; addr = a; wdata = d; tick = tk;
      #1;
      chk(int'(rd_data), model_rd(), {tag, " model rd_data"});
      if (exp >= 0) chk(int'(rd_data), exp, {tag, " directed rd_data"});
      for (int i = 0; i < 3; i++) chk(int'(ch_out[i]), m_out[i], "R10 ch_out");
      chk(int'(spk_out), (spk_ctl == 2'b11) ? m_out[2] : 0, "R12 spk_out");
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
      cyc(1'b1, 1'b0, a, d, 1'b0, tag);
   endtask
   task automatic rdx(input logic [1:0] a, input int exp, input string tag);
      cyc(1'b0, 1'b1, a, 8'd0, 1'b0, tag, exp);
   endtask
   task automatic idle(input int n, input bit tk, input string tag);
      for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 2'd0, 8'd0, tk, tag);
   endtask

   initial begin
      repeat (2) @(posedge clk);
      idle(1, 1'b0, "R2 reset");
      rst_n = 1'b1;
      idle(2, 1'b1, "R4 reset idle hold");
      rdx(2'd0, 0, "R11 access-0 read");
      rdx(2'd3, 0, "R11 control port read");
      wr(2'd3, 8'hE2, "R6 status read-back ch0");
      rdx(2'd0, 8'hC0, "R7 reset status");
      rdx(2'd0, 0, "R7 status released");
      // ch0: pair access, pulse mode, reload 5
      wr(2'd3, 8'h34, "R1 ch0 control");
      wr(2'd0, 8'h05, "R3 first byte low");
      idle(2, 1'b1, "R4 hold until high byte");
      wr(2'd0, 8'h00, "R3 second byte high");
      idle(12, 1'b1, "R8 ch0 counting");
      wr(2'd3, 8'h00, "R5 latch ch0");
      rdx(2'd0, 4, "R5 latched low");
      rdx(2'd0, 0, "R5 latched high");
      wr(2'd3, 8'h00, "R5 latch ch0 again");
      idle(2, 1'b1, "R5 ticks while latched");
      wr(2'd3, 8'h00, "R5 second latch ignored");
      rdx(2'd0, 4, "R5 first capture kept low");
      rdx(2'd0, 0, "R5 first capture kept high");
      wr(2'd3, 8'h00, "R5 relatch after release");
      rdx(2'd0, 2, "R5 new capture low");
      rdx(2'd0, 0, "R5 new capture high");
      cyc(1'b1, 1'b0, 2'd3, 8'h00, 1'b1, "R13 latch on tick");
      rdx(2'd0, 2, "R13 pre-tick value low");
      rdx(2'd0, 0, "R13 pre-tick value high");
      cyc(1'b1, 1'b0, 2'd3, 8'h34, 1'b1, "R13 control word on tick");
      wr(2'd3, 8'h00, "R13 latch after control word");
      rdx(2'd0, 1, "R13 count did not step");
      rdx(2'd0, 0, "R13 count high");
      // ch1: BCD square wave
      wr(2'd3, 8'h77, "R1 ch1 bcd control");
      wr(2'd3, 8'hE4, "R6 status ch1");
      rdx(2'd1, 8'hF7, "R7 status format");
      wr(2'd1, 8'h00, "R3 ch1 low");
      wr(2'd1, 8'h00, "R3 ch1 high");
      idle(2, 1'b1, "R9 load then step");
      wr(2'd3, 8'hC4, "R6 count and status ch1");
      rdx(2'd1, 8'hB7, "R7 status before count");
      rdx(2'd1, 8'h99, "R9 wrap low");
      rdx(2'd1, 8'h99, "R9 wrap high");
      wr(2'd1, 8'h25, "R3 write toggle first");
      wr(2'd3, 8'h40, "R5 latch ch1");
      rdx(2'd1, 8'h99, "R3 read toggle independent low");
      rdx(2'd1, 8'h99, "R3 read toggle independent high");
      wr(2'd1, 8'h00, "R3 write toggle second");
      idle(60, 1'b1, "R9 bcd period");
      // ch2: low byte only, square wave, speaker
      spk_ctl = 2'b11;
      wr(2'd3, 8'h96, "R1 ch2 control");
      wr(2'd2, 8'h03, "R4 single byte completes");
      idle(10, 1'b1, "R12 speaker on");
      spk_ctl = 2'b01;
      idle(4, 1'b1, "R12 speaker off");
      wr(2'd3, 8'h90, "R8 ch2 binary");
      wr(2'd2, 8'h00, "R8 reload zero");
      idle(2, 1'b1, "R8 load then step");
      wr(2'd3, 8'h80, "R8 latch ch2");
      rdx(2'd2, 8'hFF, "R8 wrap low");
      wr(2'd3, 8'hA0, "R3 high only control");
      wr(2'd2, 8'h01, "R3 high only write");
      idle(2, 1'b1, "R3 load then step");
      wr(2'd3, 8'h80, "R3 latch ch2");
      rdx(2'd2, 8'h00, "R3 high only read");
      wr(2'd3, 8'h96, "R2 control word resets");
      wr(2'd3, 8'hE8, "R6 status ch2");
      rdx(2'd2, 8'hD6, "R2 null count after control word");
      idle(3, 1'b0, "R11 idle bus");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule